// File: doc/BRIEF.md
# Configuration Transfer Trigger Controller

This block decides the clock cycle in which a freshly loaded shadow configuration is copied into the live configuration. It runs on the analog-domain clock and issues a single-cycle execute pulse to the copy logic. What causes that pulse depends on a two-bit mode input. In automatic mode the pulse follows the loader's end-of-bitstream strobe. In clock-sync mode the end-of-bitstream strobe prepares the copy, and the pulse comes on the first cycle in which the internal clocks are reported aligned. In event-driven mode a user event, either external or internal, fires the copy.

Event-driven mode has an optional arm stage. When the arm stage is off, the end-of-bitstream strobe arms the block and a rising edge on the external event fires it. When the arm stage is on, one source arms the block and the other fires it, and a routing bit picks which source does which. The external event is asynchronous, so it passes through a two-flop synchroniser before its rising edge is detected. The internal event is already synchronous, so its edge is taken directly. After every execute the armed state clears. The block then waits for a new arming event.

Top module: `cfg_xfer_trigger`

## Requirements
- R1: While `rst_n` is low, `exec_o` is 0 and the armed state is cleared, so an external rising edge that arrives after reset in event mode with the arm stage off produces no execute.
- R2: With `mode_i` = 0 (automatic), a one-cycle `eob_i` strobe that is sampled high at a clock edge makes `exec_o` high directly after that edge. In this mode the external and internal events have no effect.
- R3: With `mode_i` = 1 (event) and `arm_stage_en_i` = 0, `eob_i` arms the block and the next rising edge of `ext_evt_i` fires it. `int_evt_i` has no effect in this setting.
- R4: With `mode_i` = 1, `arm_stage_en_i` = 1 and `ext_arms_i` = 0, a rising edge of `int_evt_i` arms the block and a rising edge of `ext_evt_i` fires it. `eob_i` does not arm in this setting.
- R5: With `mode_i` = 1, `arm_stage_en_i` = 1 and `ext_arms_i` = 1, a rising edge of `ext_evt_i` arms the block and a rising edge of `int_evt_i` fires it. The execute appears directly after the clock edge that first samples `int_evt_i` high.
- R6: A trigger edge that arrives while the block is not armed is ignored and produces no execute.
- R7: Each execute clears the armed state, so a second trigger edge with no new arming event produces no execute.
- R8: With `mode_i` = 2 (clock sync), `eob_i` arms the block. The execute comes directly after the first clock edge at which the block is armed and `clks_aligned_i` is high. This can be the second edge after the strobe if the clocks are already aligned. If `clks_aligned_i` stays high afterwards, no further execute follows until the next `eob_i`.
- R9: When an arming edge and a trigger edge occur in the same cycle, the trigger is judged on the armed state held before that cycle, and the arming event is kept. If the block was armed, it executes and stays armed. If it was not armed, it does not execute and becomes armed.
- R10: Every execute is a pulse exactly one clock cycle wide. An external edge goes through two synchroniser flops, so the execute rises directly after the third clock edge that samples `ext_evt_i` high. This gives an event-to-execute delay of one to two analog clock periods plus synchronisation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Analog-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Transfer mode: 0 automatic, 1 event, 2 clock sync, 3 inactive |
| arm_stage_en_i | input | 1 | In event mode, turns on the separate arm stage |
| ext_arms_i | input | 1 | With the arm stage on: 1 means the external event arms and the internal event triggers; 0 means the reverse |
| ext_evt_i | input | 1 | Asynchronous external event, active on its rising edge |
| int_evt_i | input | 1 | Synchronous internal event, active on its rising edge |
| eob_i | input | 1 | End-of-bitstream strobe from the configuration loader |
| clks_aligned_i | input | 1 | High when all internal clocks are aligned |
| exec_o | output | 1 | One-cycle execute pulse for the shadow-to-active copy |

## Verification
An arming edge and a trigger edge can fall in the same cycle. The bench provokes this by raising the external event two cycles before the internal event, so that the synchronised external edge and the direct internal edge are evaluated at the same clock edge. The test runs once with the block already armed, where an execute is expected and the block stays armed. It runs once with the block not armed, where no execute is expected and the block becomes armed. In each case the bench judges the state that was kept by sending a follow-up trigger and comparing the execute cycle it predicted against the one observed.

// File: rtl/cxt_pkg.sv
package cxt_pkg;

    typedef enum logic [1:0] {
        XM_AUTO    = 2'd0,
        XM_EVENT   = 2'd1,
        XM_CLKSYNC = 2'd2,
        XM_IDLE    = 2'd3
    } xfer_mode_e;

    typedef struct packed {
        logic armed;
        logic exec;
    } fire_st_t;

    typedef struct packed {
        logic arm_evt;
        logic trig_evt;
        logic direct_fire;
    } route_t;

endpackage

// File: rtl/cxt_edge_det.sv
module cxt_edge_det #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic rise_o
);
    localparam int W = (STAGES > 0) ? STAGES : 1;

    logic lvl;
    logic prev_d, prev_q;

    generate
        if (STAGES > 0) begin : g_sync
            logic [W-1:0] chain_d, chain_q;
            always_comb begin
                chain_d    = chain_q << 1;
                chain_d[0] = d_i;
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= chain_d;
            end
            assign lvl = chain_q[W-1];
        end else begin : g_direct
            assign lvl = d_i;
        end
    endgenerate

    always_comb begin
        prev_d = lvl;
        rise_o = lvl & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/cxt_route.sv
module cxt_route
    import cxt_pkg::*;
(
    input  xfer_mode_e mode_i,
    input  logic       arm_stage_en_i,
    input  logic       ext_arms_i,
    input  logic       ext_rise_i,
    input  logic       int_rise_i,
    input  logic       eob_i,
    input  logic       aligned_i,
    output route_t     route_o
);
    always_comb begin
        route_o = '0;
        unique case (mode_i)
            XM_AUTO: begin
                route_o.direct_fire = eob_i;
            end
            XM_EVENT: begin
                if (!arm_stage_en_i) begin
                    route_o.arm_evt  = eob_i;
                    route_o.trig_evt = ext_rise_i;
                end else if (ext_arms_i) begin
                    route_o.arm_evt  = ext_rise_i;
                    route_o.trig_evt = int_rise_i;
                end else begin
                    route_o.arm_evt  = int_rise_i;
                    route_o.trig_evt = ext_rise_i;
                end
            end
            XM_CLKSYNC: begin
                route_o.arm_evt  = eob_i;
                route_o.trig_evt = aligned_i;
            end
            default: route_o = '0;
        endcase
    end
endmodule

// File: rtl/cxt_fire_fsm.sv
module cxt_fire_fsm
    import cxt_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  route_t route_i,
    output logic   armed_o,
    output logic   exec_o
);
    fire_st_t st_d, st_q;
    logic     fire;

    always_comb begin
        st_d     = st_q;
        fire     = route_i.direct_fire | (st_q.armed & route_i.trig_evt);
        st_d.exec  = fire;
        st_d.armed = (st_q.armed & ~fire) | route_i.arm_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.armed;
    assign exec_o  = st_q.exec;
endmodule

// File: rtl/cfg_xfer_trigger.sv
module cfg_xfer_trigger
    import cxt_pkg::*;
#(
    parameter int EXT_SYNC_STAGES = 2
) (
    input  logic       clk_a,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       arm_stage_en_i,
    input  logic       ext_arms_i,
    input  logic       ext_evt_i,
    input  logic       int_evt_i,
    input  logic       eob_i,
    input  logic       clks_aligned_i,
    output logic       exec_o
);
    logic   ext_rise_w;
    logic   int_rise_w;
    logic   armed_w;
    route_t route_w;

    cxt_edge_det #(.STAGES(EXT_SYNC_STAGES)) u_ext_edge (
        .clk    (clk_a),
        .rst_n  (rst_n),
        .d_i    (ext_evt_i),
        .rise_o (ext_rise_w)
    );

    cxt_edge_det #(.STAGES(0)) u_int_edge (
        .clk    (clk_a),
        .rst_n  (rst_n),
        .d_i    (int_evt_i),
        .rise_o (int_rise_w)
    );

    cxt_route u_route (
        .mode_i         (xfer_mode_e'(mode_i)),
        .arm_stage_en_i (arm_stage_en_i),
        .ext_arms_i     (ext_arms_i),
        .ext_rise_i     (ext_rise_w),
        .int_rise_i     (int_rise_w),
        .eob_i          (eob_i),
        .aligned_i      (clks_aligned_i),
        .route_o        (route_w)
    );

    cxt_fire_fsm u_fsm (
        .clk     (clk_a),
        .rst_n   (rst_n),
        .route_i (route_w),
        .armed_o (armed_w),
        .exec_o  (exec_o)
    );
endmodule

// File: rtl/cxt_checker.sv
module cxt_checker (
    input logic       clk_a,
    input logic       rst_n,
    input logic [1:0] mode_i,
    input logic       arm_stage_en_i,
    input logic       ext_arms_i,
    input logic       eob_i,
    input logic       exec_o,
    input logic       armed_w,
    input logic       ext_rise_w,
    input logic       int_rise_w
);
    // R1
    always @(posedge clk_a) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!exec_o);
        end
    end

    // R2
    auto_fire_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        (mode_i == 2'd0 && eob_i) |=> exec_o);

    // R6
    unarmed_silent_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        (mode_i != 2'd0 && !armed_w) |=> !exec_o);

    // R3
    ext_only_fires_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        (mode_i == 2'd1 && !arm_stage_en_i && !ext_rise_w) |=> !exec_o);

    // R5
    int_only_fires_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        (mode_i == 2'd1 && arm_stage_en_i && ext_arms_i && !int_rise_w) |=> !exec_o);
endmodule

bind cfg_xfer_trigger cxt_checker u_cxt_checker (
    .clk_a          (clk_a),
    .rst_n          (rst_n),
    .mode_i         (mode_i),
    .arm_stage_en_i (arm_stage_en_i),
    .ext_arms_i     (ext_arms_i),
    .eob_i          (eob_i),
    .exec_o         (exec_o),
    .armed_w        (armed_w),
    .ext_rise_w     (ext_rise_w),
    .int_rise_w     (int_rise_w)
);

// File: tb/tb_cfg_xfer_trigger.sv
module tb_cfg_xfer_trigger;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 150000;

    logic       clk_a = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       arm_stage_en_i = 1'b0;
    logic       ext_arms_i = 1'b0;
    logic       ext_evt_i = 1'b0;
    logic       int_evt_i = 1'b0;
    logic       eob_i = 1'b0;
    logic       clks_aligned_i = 1'b0;
    logic       exec_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    cfg_xfer_trigger dut (
        .clk_a          (clk_a),
        .rst_n          (rst_n),
        .mode_i         (mode_i),
        .arm_stage_en_i (arm_stage_en_i),
        .ext_arms_i     (ext_arms_i),
        .ext_evt_i      (ext_evt_i),
        .int_evt_i      (int_evt_i),
        .eob_i          (eob_i),
        .clks_aligned_i (clks_aligned_i),
        .exec_o         (exec_o)
    );

    always #(CLK_PERIOD/2) clk_a = ~clk_a;
    always @(posedge clk_a) cyc <= cyc + 1;

    // monitor: every execute seen must match the front of the scoreboard
    always @(negedge clk_a) begin
        if (rst_n && !done) begin
            if (exec_o) begin
                n_cmp++;
                if (sb_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL unexpected execute (R6/R7/R10): actual cycle %0d, expected none", cyc);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    if (e.at != cyc) begin
                        n_bad++;
                        $display("FAIL %s: execute actual cycle %0d, expected %0d", e.tag, cyc, e.at);
                    end
                end
            end else if (sb_q.size() != 0 && sb_q[0].at < cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                n_cmp++;
                n_bad++;
                $display("FAIL %s: execute actual none by cycle %0d, expected %0d", e.tag, cyc, e.at);
            end
        end
    end

    task automatic push_exp(input int off, input string tag);
        exp_t e;
        e.at  = cyc + off;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk_a);
    endtask

    // which: 0 eob, 1 ext, 2 int; off < 0 means no execute expected
    task automatic pulse(input int which, input int off, input string tag);
        @(negedge clk_a);
        case (which)
            0: eob_i = 1'b1;
            1: ext_evt_i = 1'b1;
            default: int_evt_i = 1'b1;
        endcase
        if (off >= 0) push_exp(off, tag);
        @(negedge clk_a);
        eob_i = 1'b0;
        ext_evt_i = 1'b0;
        int_evt_i = 1'b0;
        idle(5);
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen;
        seen = 1'b0;
        repeat (n) begin
            @(negedge clk_a);
            if (exec_o) seen = 1'b1;
        end
        n_cmp++;
        if (seen) begin
            n_bad++;
            $display("FAIL %s: exec_o actual 1 in quiet window, expected 0", tag);
        end
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic aen, input logic xa);
        @(negedge clk_a);
        mode_i = m;
        arm_stage_en_i = aen;
        ext_arms_i = xa;
    endtask

    // ext raised two cycles before int: both rising edges judged at the same clock edge
    task automatic both_same_cycle(input int off, input string tag);
        @(negedge clk_a);
        ext_evt_i = 1'b1;
        if (off >= 0) push_exp(off, tag);
        @(negedge clk_a);
        ext_evt_i = 1'b0;
        @(negedge clk_a);
        int_evt_i = 1'b1;
        @(negedge clk_a);
        int_evt_i = 1'b0;
        idle(5);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG_CYC);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run actual hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        idle(3);
        n_cmp++;
        if (exec_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R1: exec_o in reset actual %b, expected 0", exec_o);
        end
        @(negedge clk_a);
        rst_n = 1'b1;
        idle(2);

        // R1: armed cleared by reset, ext edge alone does nothing
        set_cfg(2'd1, 1'b0, 1'b0);
        pulse(1, -1, "R1");
        quiet(4, "R1");

        // R2 automatic mode
        set_cfg(2'd0, 1'b0, 1'b0);
        pulse(0, 1, "R2");
        pulse(0, 1, "R2");
        pulse(1, -1, "R2");
        pulse(2, -1, "R2");
        quiet(4, "R2");

        // R3 event, no arm stage; R10 ext latency
        set_cfg(2'd1, 1'b0, 1'b0);
        pulse(0, -1, "R3");
        pulse(2, -1, "R3");
        quiet(3, "R3");
        pulse(1, 3, "R3_R10");
        pulse(1, -1, "R7");
        quiet(4, "R7");
        pulse(0, -1, "R3");
        pulse(1, 3, "R3");

        // R4 int arms, ext triggers; eob must not arm
        set_cfg(2'd1, 1'b1, 1'b0);
        pulse(0, -1, "R4");
        pulse(1, -1, "R4_R6");
        quiet(4, "R4");
        pulse(2, -1, "R4");
        pulse(1, 3, "R4");

        // R5 ext arms, int triggers
        set_cfg(2'd1, 1'b1, 1'b1);
        pulse(2, -1, "R5_R6");
        quiet(3, "R5");
        pulse(1, -1, "R5");
        pulse(2, 1, "R5");
        pulse(2, -1, "R7");
        quiet(4, "R7");

        // R9 same-cycle arm and trigger, int arms / ext triggers
        set_cfg(2'd1, 1'b1, 1'b0);
        pulse(2, -1, "R9");
        both_same_cycle(3, "R9");
        pulse(1, 3, "R9");
        both_same_cycle(-1, "R9");
        quiet(3, "R9");
        pulse(1, 3, "R9");

        // R8 clock-sync mode
        set_cfg(2'd2, 1'b0, 1'b0);
        @(negedge clk_a);
        clks_aligned_i = 1'b1;
        pulse(0, 2, "R8");
        quiet(8, "R8");
        @(negedge clk_a);
        clks_aligned_i = 1'b0;
        pulse(0, -1, "R8");
        quiet(3, "R8");
        @(negedge clk_a);
        clks_aligned_i = 1'b1;
        push_exp(1, "R8");
        idle(6);
        clks_aligned_i = 1'b0;

        idle(10);
        n_cmp++;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R10: pending executes actual %0d, expected 0", sb_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule